// File: doc/BRIEF.md
# Two-Source Interrupt Dispatch Controller

This block decides when a small 8-bit CPU core is diverted into an interrupt handler. It serves two interrupt sources: a frame-blank source and a timer source. The request flags stay inside their peripherals. The block only mirrors those flags into one request view. A register write can set or clear each flag through per-source load strobes. The block keeps a byte-wide enable register, a master enable, and a halted state. It reads and writes the enable and request views through a byte-wide register port.

A dispatch starts when all of the following hold at a clock edge:
- the core reports an instruction boundary;
- the master enable is set;
- no earlier dispatch is still running;
- at least one source has both its enable bit and its flag set.

One source is serviced per dispatch, and the frame-blank source wins over the timer. In that edge the block clears the master enable and releases halt. In the following cycle it pulses a push-PC/jump request to the core with a fixed vector, together with a one-cycle acknowledge to the serviced peripheral. The dispatch then holds a busy indication for a fixed number of cycles.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: The enable register lives at address 0xFFFF. All 8 bits are written by a register write to that address and read back unchanged. It resets to 0.
- R2: A read of 0xFF0F returns the frame-blank flag (src_flag[0]) in bit 0 and the timer flag (src_flag[1]) in bit 2. The other bits read as 0, and any other address reads as 0.
- R3: A write to 0xFF0F raises flag_load for both sources in the same cycle. The value for the frame-blank source is data bit 0 and the value for the timer source is data bit 2. A write to any other address raises no flag_load.
- R4: A dispatch starts at a clock edge only when at_boundary is 1, ime is 1, disp_busy is 0, and some source has both its flag and its enable bit set. The enable bits are bit 0 for frame-blank and bit 2 for timer. Otherwise jmp_req stays 0.
- R5: jmp_req is a one-cycle pulse in the cycle after the starting edge. jmp_vec is 0x0040 when the frame-blank source is serviced and 0x0050 for the timer. Frame-blank is chosen when both are pending.
- R6: src_ack pulses for exactly one cycle, together with jmp_req, and only on the bit of the serviced source (bit 0 frame-blank, bit 1 timer). Otherwise it is 0.
- R7: ime_set sets the master enable and ime_clr clears it, with ime_clr winning when both arrive together. A dispatch start clears it regardless of either input. It resets to 0.
- R8: halt_req sets halted. A dispatch start clears halted, overriding halt_req in the same edge.
- R9: disp_busy is 1 for exactly DISP_CYCLES (default 16) cycles, starting with the jmp_req cycle. No new dispatch starts while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| src_flag | input | 2 | Peripheral request flags, bit 0 frame-blank, bit 1 timer |
| flag_load | output | 2 | Per-source flag load strobe |
| flag_load_val | output | 2 | Value to load into each source flag |
| src_ack | output | 2 | Per-source acknowledge pulse (peripheral clears its flag) |
| at_boundary | input | 1 | Core may accept a dispatch this cycle |
| ime_set | input | 1 | Enable master interrupt enable |
| ime_clr | input | 1 | Disable master interrupt enable |
| halt_req | input | 1 | Core enters halt |
| ime | output | 1 | Master interrupt enable state |
| halted | output | 1 | Core halt state |
| jmp_req | output | 1 | Push-PC/jump request pulse |
| jmp_vec | output | 16 | Handler vector address |
| disp_busy | output | 1 | Dispatch window in progress |

## Verification
The bench builds the block with its default parameters: a 16-cycle dispatch window and the two fixed register addresses. This lets the reference model follow whole dispatch windows end to end. The bench also re-arms the master enable inside a window, which shows that a pending timer waits for the window to close. With these values the bench can place both sources pending at once, disabled sources, a closed master enable, and coincident enable/disable and halt/dispatch edges within a short run.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 2;
  localparam int SRC_FRAME = 0;
  localparam int SRC_TIMER = 1;

  // bit position of a source in the enable and request views
  function automatic int src_bit(input int idx);
    return idx * 2;
  endfunction

  // handler vector for a source
  function automatic logic [15:0] src_vector(input int idx);
    return 16'h0040 + 16'(idx) * 16'h0010;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IE_ADDR  = 16'hFFFF,
  parameter logic [ADDR_W-1:0] REQ_ADDR = 16'hFF0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   src_flag,
  output logic [DATA_W-1:0] ie_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NSRC-1:0]   flag_load,
  output logic [NSRC-1:0]   flag_load_val
);
  logic hit_ie, hit_req;
  logic [DATA_W-1:0] req_view;

  assign hit_ie  = (reg_addr == IE_ADDR);
  assign hit_req = (reg_addr == REQ_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ie_q <= '0;
    else if (reg_wr && hit_ie) ie_q <= reg_wdata;
  end

  always_comb begin
    req_view = '0;
    for (int i = 0; i < NSRC; i++) req_view[src_bit(i)] = src_flag[i];
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_load
    assign flag_load[g]     = reg_wr && hit_req;
    assign flag_load_val[g] = reg_wdata[src_bit(g)];
  end

  always_comb begin
    if (hit_ie)       reg_rdata = ie_q;
    else if (hit_req) reg_rdata = req_view;
    else              reg_rdata = '0;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ie_q,
  input  logic [NSRC-1:0]   src_flag,
  output logic              pend_any,
  output logic [NSRC-1:0]   sel,
  output logic [15:0]       vec
);
  logic [NSRC-1:0] pend;

  for (genvar g = 0; g < NSRC; g++) begin : g_pend
    assign pend[g] = src_flag[g] & ie_q[src_bit(g)];
  end

  assign pend_any = |pend;

  // lowest index wins
  always_comb begin
    sel = '0;
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        vec    = src_vector(i);
      end
    end
  end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter int DISP_CYCLES = 16,
  localparam int CNT_W = $clog2(DISP_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            at_boundary,
  input  logic            ime_set,
  input  logic            ime_clr,
  input  logic            halt_req,
  input  logic            pend_any,
  input  logic [NSRC-1:0] sel,
  input  logic [15:0]     vec,
  output logic            start,
  output logic            ime,
  output logic            halted,
  output logic            jmp_req,
  output logic [15:0]     jmp_vec,
  output logic [NSRC-1:0] src_ack,
  output logic            disp_busy
);
  logic [CNT_W-1:0] cnt;

  assign disp_busy = (cnt != '0);
  assign start     = at_boundary && ime && !disp_busy && pend_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime     <= 1'b0;
      halted  <= 1'b0;
      cnt     <= '0;
      jmp_req <= 1'b0;
      jmp_vec <= '0;
      src_ack <= '0;
    end else begin
      if (start)        ime <= 1'b0;
      else if (ime_clr) ime <= 1'b0;
      else if (ime_set) ime <= 1'b1;

      if (start)         halted <= 1'b0;
      else if (halt_req) halted <= 1'b1;

      if (start)          cnt <= CNT_W'(DISP_CYCLES);
      else if (disp_busy) cnt <= cnt - 1'b1;

      jmp_req <= start;
      src_ack <= start ? sel : '0;
      if (start) jmp_vec <= vec;
    end
  end
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IE_ADDR  = 16'hFFFF,
  parameter logic [ADDR_W-1:0] REQ_ADDR = 16'hFF0F,
  parameter int DISP_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        src_flag,
  output logic [1:0]        flag_load,
  output logic [1:0]        flag_load_val,
  output logic [1:0]        src_ack,
  input  logic              at_boundary,
  input  logic              ime_set,
  input  logic              ime_clr,
  input  logic              halt_req,
  output logic              ime,
  output logic              halted,
  output logic              jmp_req,
  output logic [15:0]       jmp_vec,
  output logic              disp_busy
);
  logic [DATA_W-1:0] ie_q;
  logic              pend_any;
  logic [NSRC-1:0]   sel;
  logic [15:0]       vec;
  logic              start;

  irq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IE_ADDR(IE_ADDR), .REQ_ADDR(REQ_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .src_flag(src_flag), .ie_q(ie_q),
    .reg_rdata(reg_rdata), .flag_load(flag_load), .flag_load_val(flag_load_val)
  );

  irq_arbiter #(.DATA_W(DATA_W)) u_arb (
    .ie_q(ie_q), .src_flag(src_flag), .pend_any(pend_any), .sel(sel), .vec(vec)
  );

  irq_sequencer #(.DISP_CYCLES(DISP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .ime_set(ime_set),
    .ime_clr(ime_clr), .halt_req(halt_req), .pend_any(pend_any), .sel(sel),
    .vec(vec), .start(start), .ime(ime), .halted(halted), .jmp_req(jmp_req),
    .jmp_vec(jmp_vec), .src_ack(src_ack), .disp_busy(disp_busy)
  );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int DISP_CYCLES = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ie_q,
  input logic [1:0]        src_flag,
  input logic [1:0]        src_ack,
  input logic              ime,
  input logic              halted,
  input logic              jmp_req,
  input logic [15:0]       jmp_vec,
  input logic              disp_busy
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= 0;
    else if (disp_busy) run <= run + 1;
    else                run <= 0;
  end

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_req |-> $countones(src_ack) == 1);
  assert_ack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_req |-> src_ack == 2'b00);
  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_req |-> (jmp_vec == 16'h0040 && src_ack[0]) || (jmp_vec == 16'h0050 && src_ack[1]));
  assert_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_req && $past(ie_q[0] && src_flag[0])) |-> src_ack[0]);
  assert_need_ime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_req |-> $past(ime));
  assert_ime_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_req |-> !ime);
  assert_halt_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_req |-> !halted);
  assert_busy_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_req |-> disp_busy && !$past(disp_busy));
  assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_busy) |-> run == DISP_CYCLES);
endmodule

bind irq_dispatch_ctrl irq_dispatch_chk #(.DISP_CYCLES(DISP_CYCLES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ie_q(ie_q), .src_flag(src_flag), .src_ack(src_ack),
  .ime(ime), .halted(halted), .jmp_req(jmp_req), .jmp_vec(jmp_vec),
  .disp_busy(disp_busy)
);

// File: tb/irq_dispatch_ctrl_tb.sv
module irq_dispatch_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] reg_addr = 16'h0000;
  logic        reg_wr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [1:0]  src_flag;
  logic [1:0]  flag_load, flag_load_val, src_ack;
  logic        at_boundary = 0, ime_set = 0, ime_clr = 0, halt_req = 0;
  logic        ime, halted, jmp_req, disp_busy;
  logic [15:0] jmp_vec;
  logic [1:0]  raise = 0;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_dispatch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_flag(src_flag),
    .flag_load(flag_load), .flag_load_val(flag_load_val), .src_ack(src_ack),
    .at_boundary(at_boundary), .ime_set(ime_set), .ime_clr(ime_clr),
    .halt_req(halt_req), .ime(ime), .halted(halted), .jmp_req(jmp_req),
    .jmp_vec(jmp_vec), .disp_busy(disp_busy)
  );

  // behavioural reference: peripheral flags plus controller state
  logic [1:0] pf = 0;
  logic [7:0] m_ie = 0;
  bit   m_ime = 0, m_halt = 0, m_jr = 0;
  int   m_left = 0;
  logic [15:0] m_vec = 0;
  logic [1:0]  m_ack = 0;
  assign src_flag = pf;

  always @(posedge clk) begin
    bit wr_req, frm, tmr, go;
    logic [1:0] nf;
    if (!rst_n) begin
      pf <= 0; m_ie <= 0; m_ime <= 0; m_halt <= 0; m_jr <= 0;
      m_left <= 0; m_vec <= 0; m_ack <= 0;
    end else begin
      wr_req = reg_wr && reg_addr == 16'hFF0F;
      frm = pf[0] && m_ie[0];
      tmr = pf[1] && m_ie[2];
      go  = at_boundary && m_ime && m_left == 0 && (frm || tmr);
      nf = pf & ~m_ack;
      nf = nf | raise;
      if (wr_req) nf = {reg_wdata[2], reg_wdata[0]};
      pf <= nf;
      if (reg_wr && reg_addr == 16'hFFFF) m_ie <= reg_wdata;
      m_ime  <= go ? 0 : (ime_clr ? 0 : (ime_set ? 1 : m_ime));
      m_halt <= go ? 0 : (halt_req ? 1 : m_halt);
      m_left <= go ? 16 : (m_left > 0 ? m_left - 1 : 0);
      m_jr   <= go;
      m_ack  <= go ? (frm ? 2'b01 : 2'b10) : 2'b00;
      if (go) m_vec <= frm ? 16'h0040 : 16'h0050;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle away from the edge
  always @(negedge clk) begin
    logic [7:0] er;
    if (rst_n && !done) begin
      if (reg_addr == 16'hFFFF)      er = m_ie;
      else if (reg_addr == 16'hFF0F) er = {5'b0, pf[1], 1'b0, pf[0]};
      else                           er = 0;
      chk(reg_addr == 16'hFFFF ? "R1 rdata" : "R2 rdata", 16'(reg_rdata), 16'(er));
      chk("R3 load", 16'(flag_load), (reg_wr && reg_addr == 16'hFF0F) ? 16'h3 : 16'h0);
      if (reg_wr && reg_addr == 16'hFF0F)
        chk("R3 loadval", 16'(flag_load_val), 16'({reg_wdata[2], reg_wdata[0]}));
      chk("R4 jmp_req", 16'(jmp_req), 16'(m_jr));
      if (m_jr) chk("R5 jmp_vec", jmp_vec, m_vec);
      chk("R6 src_ack", 16'(src_ack), 16'(m_ack));
      chk("R7 ime", 16'(ime), 16'(m_ime));
      chk("R8 halted", 16'(halted), 16'(m_halt));
      chk("R9 busy", 16'(disp_busy), 16'(m_left != 0));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse_ime_set();
    @(negedge clk); ime_set = 1;
    @(negedge clk); ime_set = 0;
  endtask

  initial begin
    idle(3);
    // reset state, checked before release
    compared++;
    if (ime !== 0 || halted !== 0 || jmp_req !== 0 || disp_busy !== 0 || src_ack !== 0) begin
      mismatched++;
      $display("FAIL R7 reset actual=%b%b%b%b expected=0000", ime, halted, jmp_req, disp_busy);
    end
    rst_n = 1;
    // R1 enable register read/write
    reg_addr = 16'hFFFF; idle(1);
    wr(16'hFFFF, 8'hA5); idle(1);
    wr(16'hFFFF, 8'h05);
    // R2 request view
    reg_addr = 16'hFF0F; idle(1);
    @(negedge clk); raise = 2'b10; @(negedge clk); raise = 0; idle(1);
    reg_addr = 16'hFF10; idle(1);
    reg_addr = 16'hFF0F;
    // R4 no dispatch while ime is clear
    at_boundary = 1; idle(4);
    // R3 load both flags, then clear them
    wr(16'hFF0F, 8'hFF); idle(1);
    wr(16'hFF0F, 8'h00); idle(1);
    wr(16'hFF0F, 8'h05);
    // R8 halt then R5 priority dispatch of frame-blank
    @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
    pulse_ime_set();
    // R9 re-enable inside the window; timer waits for it to close
    idle(4); pulse_ime_set(); idle(20);
    // R4 disabled timer source: no dispatch
    wr(16'hFFFF, 8'h01);
    @(negedge clk); raise = 2'b10; @(negedge clk); raise = 0;
    pulse_ime_set(); idle(4);
    // R7 set and clear together: clear wins
    @(negedge clk); ime_set = 1; ime_clr = 1; @(negedge clk); ime_set = 0; ime_clr = 0;
    // R4 boundary low blocks, then dispatch of frame-blank with coincident halt_req
    at_boundary = 0;
    @(negedge clk); raise = 2'b01; @(negedge clk); raise = 0;
    pulse_ime_set(); idle(3);
    @(negedge clk); at_boundary = 1; halt_req = 1; @(negedge clk); halt_req = 0;
    idle(20);
    // R6 timer re-enabled, both pending: frame-blank first, then timer
    wr(16'hFFFF, 8'h05);
    @(negedge clk); raise = 2'b11; @(negedge clk); raise = 0;
    pulse_ime_set(); idle(18); pulse_ime_set(); idle(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule